// File: doc/BRIEF.md
# Dual-Port DSP Address Generator

This block computes the data-memory addresses for a signal-processing core that reads its X and Y memories in the same cycle. It holds a small bank of pointer registers. Each pointer has its own signed step, a buffer length and a 2-bit update mode. An access selects one pointer, presents its value at once as the memory address, and writes back the modified pointer at the next clock edge. The update may be a plain add, a modulo-buffer wrap, or a carry-reversed add that walks a power-of-two block in bit-reversed order, as an FFT needs.

Two access ports, X and Y, each have their own update datapath. One X access and one Y access can therefore both post-modify in the same cycle. A configuration write port loads any field of any pointer. When the two ports and the configuration port touch the same register, fixed priorities decide the result, so software and the sequencer see a defined outcome.

Top module: `dsp_agu`

## Requirements
- R1: After reset every pointer, step, length and mode field is zero, so both address outputs read 0 for every register index.
- R2: `x_addr` and `y_addr` show, without any clock delay, the current value of the register chosen by `x_idx` and `y_idx`, whether or not the request is high.
- R3: In mode 00 (linear), an access sets the pointer to pointer + step modulo 2^16 at the next clock edge. The step is a two's-complement 16-bit value.
- R4: In mode 01 (circular) with a nonzero length L and a positive step, the buffer base is the pointer with its low ceil(log2 L) bits cleared. The pointer advances by the step and wraps back into [base, base+L-1].
- R5: In mode 01 with a negative step, a pointer that would fall below the base wraps to the top of the same buffer. Steps must satisfy |step| <= L.
- R6: In mode 10 (bit-reverse), with L a power of two 2^N, the step is added to the low N bits with the carry moving from bit N-1 toward bit 0. The carry out of bit 0 is dropped and the bits above N-1 are kept.
- R7: An X access and a Y access to two different registers in the same cycle both write back their updated pointers.
- R8: If X and Y select the same register in one cycle, `y_addr` equals `x_addr` (the value before the update), the register takes X's result, and Y's update is discarded.
- R9: In a cycle with no access and no configuration write, no pointer changes.
- R10: A configuration write loads the field chosen by `cfg_field` (00 pointer, 01 step, 10 length, 11 mode). A pointer write overrides any post-modify of the same register in that cycle.
- R11: Mode 11, and mode 01 with length 0, update the pointer in the linear way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Register index for the configuration write |
| cfg_field | input | 2 | Field select: 00 pointer, 01 step, 10 length, 11 mode |
| cfg_wdata | input | 16 | Configuration data (mode uses bits 1:0) |
| x_req | input | 1 | X memory access request |
| x_idx | input | 2 | Register index used by the X access |
| x_addr | output | 16 | X memory address |
| y_req | input | 1 | Y memory access request |
| y_idx | input | 2 | Register index used by the Y access |
| y_addr | output | 16 | Y memory address |

## Verification
The bound checker watches four things on every cycle: pointers stay still when the block is idle, the two ports agree on a shared register, a linear update or a collision writes back the expected value, and a pointer write lands at the next edge. Other behaviour shows only in the bench scenarios. These are the wrap points of the modulo buffer in both directions, the bit-reversed visiting order across a full block, the reset state, and the reserved and zero-length fallbacks. The bench checks them against its own arithmetic model, one address at a time.

// File: rtl/dsp_agu_pkg.sv
package dsp_agu_pkg;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'b00,
    MODE_CIRC = 2'b01,
    MODE_BREV = 2'b10,
    MODE_RSVD = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    FLD_PTR  = 2'b00,
    FLD_STEP = 2'b01,
    FLD_LEN  = 2'b10,
    FLD_MODE = 2'b11
  } agu_field_e;

  localparam int unsigned AGU_PORTS = 2;

endpackage

// File: rtl/dsp_agu_update.sv
module dsp_agu_update
  import dsp_agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt
);

  localparam int unsigned SW = AW + 2;

  function automatic logic [AW-1:0] rev_bits(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  // smallest all-ones mask 2^k-1 with 2^k >= l
  function automatic logic [AW-1:0] span_mask(input logic [AW-1:0] l);
    logic [AW-1:0] m;
    m = '0;
    for (int i = 0; i < AW; i++)
      if (({1'b0, m} + 1'b1) < {1'b0, l}) m = {m[AW-2:0], 1'b1};
    return m;
  endfunction

  function automatic logic [AW-1:0] lin_next(input logic [AW-1:0] a,
                                             input logic [AW-1:0] s);
    return a + s;
  endfunction

  function automatic logic [AW-1:0] circ_next(input logic [AW-1:0] a,
                                              input logic [AW-1:0] s,
                                              input logic [AW-1:0] l);
    logic [AW-1:0]        msk;
    logic signed [SW-1:0] off;
    logic signed [SW-1:0] lim;
    msk = span_mask(l);
    off = $signed({2'b00, a & msk}) + $signed({{2{s[AW-1]}}, s});
    lim = $signed({2'b00, l});
    if (off >= lim)           off = off - lim;
    else if (off < 0)         off = off + lim;
    return (a & ~msk) | off[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] brev_next(input logic [AW-1:0] a,
                                              input logic [AW-1:0] s,
                                              input logic [AW-1:0] l);
    logic [AW-1:0] msk;
    logic [AW-1:0] fld;
    msk = l - 1'b1;
    fld = rev_bits(rev_bits(a & msk) + rev_bits(s & msk)) & msk;
    return (a & ~msk) | fld;
  endfunction

  always_comb begin
    case (agu_mode_e'(mode))
      MODE_CIRC: nxt = (len == '0) ? lin_next(cur, step) : circ_next(cur, step, len);
      MODE_BREV: nxt = brev_next(cur, step, len);
      default:   nxt = lin_next(cur, step);
    endcase
  end

endmodule

// File: rtl/dsp_agu_regfile.sv
module dsp_agu_regfile
  import dsp_agu_pkg::*;
#(
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 16,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [IW-1:0]                  cfg_idx,
  input  logic [1:0]                     cfg_field,
  input  logic [AW-1:0]                  cfg_wdata,
  input  logic [AGU_PORTS-1:0]           wb_en,
  input  logic [AGU_PORTS-1:0][IW-1:0]   wb_idx,
  input  logic [AGU_PORTS-1:0][AW-1:0]   wb_data,
  output logic [NREG-1:0][AW-1:0]        ptr_q,
  output logic [NREG-1:0][AW-1:0]        step_q,
  output logic [NREG-1:0][AW-1:0]        len_q,
  output logic [NREG-1:0][1:0]           mode_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic cfg_hit;
    assign cfg_hit = cfg_we && (cfg_idx == IW'(g));

    // later statements win: Y write-back, then X, then configuration
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else begin
        for (int p = AGU_PORTS - 1; p >= 0; p--)
          if (wb_en[p] && (wb_idx[p] == IW'(g))) ptr_q[g] <= wb_data[p];
        if (cfg_hit && (agu_field_e'(cfg_field) == FLD_PTR)) ptr_q[g] <= cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_q[g] <= '0;
        len_q[g]  <= '0;
        mode_q[g] <= '0;
      end else if (cfg_hit) begin
        case (agu_field_e'(cfg_field))
          FLD_STEP: step_q[g] <= cfg_wdata;
          FLD_LEN:  len_q[g]  <= cfg_wdata;
          FLD_MODE: mode_q[g] <= cfg_wdata[1:0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import dsp_agu_pkg::*;
#(
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 16,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_field,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          x_req,
  input  logic [IW-1:0] x_idx,
  output logic [AW-1:0] x_addr,
  input  logic          y_req,
  input  logic [IW-1:0] y_idx,
  output logic [AW-1:0] y_addr
);

  logic [NREG-1:0][AW-1:0]      ptr_q;
  logic [NREG-1:0][AW-1:0]      step_q;
  logic [NREG-1:0][AW-1:0]      len_q;
  logic [NREG-1:0][1:0]         mode_q;

  logic [AGU_PORTS-1:0]         req_v;
  logic [AGU_PORTS-1:0][IW-1:0] idx_v;
  logic [AGU_PORTS-1:0][AW-1:0] cur_v;
  logic [AGU_PORTS-1:0][AW-1:0] nxt_v;
  logic [AGU_PORTS-1:0]         wb_en;

  // named events for the checker
  logic          y_collide;
  logic [AW-1:0] x_next;

  assign req_v = {y_req, x_req};
  assign idx_v = {y_idx, x_idx};

  for (genvar p = 0; p < AGU_PORTS; p++) begin : g_port
    assign cur_v[p] = ptr_q[idx_v[p]];

    dsp_agu_update #(.AW(AW)) u_upd (
      .cur  (cur_v[p]),
      .step (step_q[idx_v[p]]),
      .len  (len_q[idx_v[p]]),
      .mode (mode_q[idx_v[p]]),
      .nxt  (nxt_v[p])
    );
  end

  assign y_collide = x_req && y_req && (x_idx == y_idx);
  assign wb_en     = {y_req && !y_collide, x_req};
  assign x_next    = nxt_v[0];
  assign x_addr    = cur_v[0];
  assign y_addr    = cur_v[1];

  dsp_agu_regfile #(.NREG(NREG), .AW(AW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .wb_en     (wb_en),
    .wb_idx    (idx_v),
    .wb_data   (nxt_v),
    .ptr_q     (ptr_q),
    .step_q    (step_q),
    .len_q     (len_q),
    .mode_q    (mode_q)
  );

endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
  parameter int unsigned NREG = 4,
  parameter int unsigned AW   = 16,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [IW-1:0]           cfg_idx,
  input logic [1:0]              cfg_field,
  input logic [AW-1:0]           cfg_wdata,
  input logic                    x_req,
  input logic [IW-1:0]           x_idx,
  input logic [AW-1:0]           x_addr,
  input logic                    y_req,
  input logic [IW-1:0]           y_idx,
  input logic [AW-1:0]           y_addr,
  input logic [AW-1:0]           x_next,
  input logic [NREG-1:0][AW-1:0] ptr_q,
  input logic [NREG-1:0][AW-1:0] step_q,
  input logic [NREG-1:0][1:0]    mode_q
);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_req && !y_req && !cfg_we) |=> $stable(ptr_q));

  // R8
  shared_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && y_req && x_idx == y_idx) |-> (y_addr == x_addr));

  // R8
  x_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && y_req && x_idx == y_idx && !cfg_we) |=> (ptr_q[$past(x_idx)] == $past(x_next)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && mode_q[x_idx] == 2'b00 && !(cfg_we && cfg_idx == x_idx))
    |=> (ptr_q[$past(x_idx)] == $past(x_addr + step_q[x_idx])));

  // R10
  cfg_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 2'b00) |=> (ptr_q[$past(cfg_idx)] == $past(cfg_wdata)));

endmodule

bind dsp_agu dsp_agu_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_idx   (cfg_idx),
  .cfg_field (cfg_field),
  .cfg_wdata (cfg_wdata),
  .x_req     (x_req),
  .x_idx     (x_idx),
  .x_addr    (x_addr),
  .y_req     (y_req),
  .y_idx     (y_idx),
  .y_addr    (y_addr),
  .x_next    (x_next),
  .ptr_q     (ptr_q),
  .step_q    (step_q),
  .mode_q    (mode_q)
);

// File: tb/dsp_agu_tb.sv
`timescale 1ns/1ps
module dsp_agu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [1:0]  cfg_field = '0;
  logic [15:0] cfg_wdata = '0;
  logic        x_req = 1'b0;
  logic [1:0]  x_idx = '0;
  logic [15:0] x_addr;
  logic        y_req = 1'b0;
  logic [1:0]  y_idx = '0;
  logic [15:0] y_addr;

  always #2 clk = ~clk;

  dsp_agu u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .x_req(x_req), .x_idx(x_idx), .x_addr(x_addr),
    .y_req(y_req), .y_idx(y_idx), .y_addr(y_addr)
  );

  typedef struct {
    string tag;
    int    port;
    int    exp;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  int m_ptr[4];
  int m_step[4];
  int m_len[4];
  int m_mode[4];

  // ---------------- bench model ----------------
  function automatic int sgn(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int mdl_next(input int i);
    int a, s, l, pw, base, off, n, r, c, sum, msk;
    a = m_ptr[i]; s = m_step[i]; l = m_len[i];
    if (m_mode[i] == 1 && l != 0) begin
      pw = 1;
      while (pw < l) pw = pw * 2;
      base = a - (a % pw);
      off  = (a % pw) + sgn(s);
      off  = ((off % l) + l) % l;
      return base + off;
    end else if (m_mode[i] == 2) begin
      n = 0;
      while ((1 << n) < l) n++;
      msk = (1 << n) - 1;
      r = a & msk; c = 0;
      for (int b = n - 1; b >= 0; b--) begin
        sum = ((r >> b) & 1) + ((s >> b) & 1) + c;
        r   = (r & ~(1 << b)) | ((sum & 1) << b);
        c   = sum >> 1;
      end
      return (a & ~msk & 65535) | r;
    end
    return (a + s) & 65535;
  endfunction

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it  = q.pop_front();
        act = (it.port == 0) ? int'(x_addr) : int'(y_addr);
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic cycle(input bit xr, input int xi, input bit yr, input int yi,
                       input bit cw, input int ci, input int cf, input int cd,
                       input string tag);
    int nx, ny;
    @(negedge clk);
    x_req = xr; x_idx = 2'(xi); y_req = yr; y_idx = 2'(yi);
    cfg_we = cw; cfg_idx = 2'(ci); cfg_field = 2'(cf); cfg_wdata = 16'(cd);
    #1;
    q.push_back('{tag, 0, m_ptr[xi]});
    q.push_back('{tag, 1, m_ptr[yi]});
    ->sample_ev;
    nx = mdl_next(xi);
    ny = mdl_next(yi);
    if (yr && !(xr && xi == yi)) m_ptr[yi] = ny;
    if (xr) m_ptr[xi] = nx;
    if (cw) begin
      case (cf)
        0: m_ptr[ci]  = cd & 65535;
        1: m_step[ci] = cd & 65535;
        2: m_len[ci]  = cd & 65535;
        default: m_mode[ci] = cd & 3;
      endcase
    end
  endtask

  task automatic cfg(input int ci, input int cf, input int cd);
    cycle(0, ci, 0, ci, 1, ci, cf, cd, "R10");
  endtask

  task automatic setup(input int ci, input int p, input int s, input int l, input int md);
    cfg(ci, 0, p); cfg(ci, 1, s); cfg(ci, 2, l); cfg(ci, 3, md);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_ptr[i] = 0; m_step[i] = 0; m_len[i] = 0; m_mode[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state visible on both ports
    for (int i = 0; i < 4; i++) cycle(0, i, 0, 3 - i, 0, 0, 0, 0, "R1");

    // R3: linear, positive then wrapping negative step
    setup(0, 100, 3, 0, 0);
    repeat (3) cycle(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    setup(0, 0, 16'hFFFF, 0, 0);
    repeat (2) cycle(1, 0, 0, 0, 0, 0, 0, 0, "R3");

    // R4: circular, length 5, step +2
    setup(1, 16'h0020, 2, 5, 1);
    repeat (7) cycle(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    // R5: circular, step -2
    cfg(1, 0, 16'h0021); cfg(1, 1, 16'hFFFE);
    repeat (6) cycle(0, 0, 1, 1, 0, 0, 0, 0, "R5");

    // R6: bit-reverse, block of 8, step 1 then step 2
    setup(2, 16'h0040, 1, 8, 2);
    repeat (9) cycle(0, 0, 1, 2, 0, 0, 0, 0, "R6");
    setup(2, 16'h1230, 2, 16, 2);
    repeat (5) cycle(1, 2, 0, 0, 0, 0, 0, 0, "R6");

    // R7: both ports, different registers
    setup(0, 10, 1, 0, 0);
    setup(2, 16'h0040, 4, 8, 2);
    repeat (4) cycle(1, 0, 1, 2, 0, 0, 0, 0, "R7");

    // R8: both ports on the same register
    repeat (3) cycle(1, 1, 1, 1, 0, 0, 0, 0, "R8");

    // R9: idle cycles, pointers held
    for (int i = 0; i < 4; i++) cycle(0, i, 0, (i + 1) % 4, 0, 0, 0, 0, "R9");

    // R10: pointer write overrides post-modify in the same cycle
    cycle(1, 0, 1, 0, 1, 0, 0, 16'h0500, "R10");
    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10");

    // R11: reserved mode, and circular with zero length
    setup(3, 7, 2, 0, 3);
    repeat (3) cycle(1, 3, 0, 0, 0, 0, 0, 0, "R11");
    setup(3, 16'hFFFE, 3, 0, 1);
    repeat (3) cycle(0, 0, 1, 3, 0, 0, 0, 0, "R11");

    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule